// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This engine clears or initialises up to two regions of a word-addressed memory with a repeating 32-bit pattern. Each channel is given a first address, a stop address (exclusive) and a pattern word. A single start strobe captures all six values and launches the job. The engine then issues one write per cycle on a plain single-port write interface: channel 0's region first, then channel 1's region, then a one-cycle done pulse.

A channel whose first address is zero is disabled and is passed over without comment. A channel with a nonzero first address and a stop address at or below it is malformed. It is rejected: the engine raises that channel's error flag, issues no writes for it, and still services the other channel. Requests made while a job is running are dropped. Software sees completion through the done pulse, which fires even when neither channel wrote anything.

Top module: `mfill_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are low and err_o is 2'b00.
- R2: For a valid channel (first address nonzero, stop address greater than first), the engine writes that channel's pattern to every address from first up to stop-1, ascending, one write per cycle with no gaps. When channel 0 is valid, its first write appears in the cycle after the clock edge that accepts the start strobe.
- R3: Channel 1's writes begin in the cycle immediately after channel 0's last write. If channel 0 produces no writes, channel 1's writes begin in the cycle after acceptance.
- R4: A channel whose first address is zero issues no writes and does not set its error flag.
- R5: A channel with a nonzero first address and a stop address less than or equal to it issues no writes. It sets its error flag: err_o bit 0 for channel 0, bit 1 for channel 1. The other channel is processed normally.
- R6: err_o takes its new value in the cycle after a start is accepted. It then holds that value until the next accepted start, which replaces it.
- R7: done_o is high for exactly one cycle, in the cycle after the last write. If no channel writes, it is high in the cycle after acceptance. mem_we_o is low while done_o is high.
- R8: busy_o is high from the cycle after acceptance through the done cycle, and is low otherwise. A start strobe seen while busy_o is high has no effect on the writes, on done_o or on err_o.
- R9: Channel parameters are captured when the start is accepted. Changes on the parameter inputs while busy do not alter the addresses or data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| c0_first_i | input | AW | Channel 0 first address (0 disables the channel) |
| c0_stop_i | input | AW | Channel 0 stop address, exclusive |
| c0_pattern_i | input | DW | Channel 0 fill word |
| c1_first_i | input | AW | Channel 1 first address (0 disables the channel) |
| c1_stop_i | input | AW | Channel 1 stop address, exclusive |
| c1_pattern_i | input | DW | Channel 1 fill word |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Per-channel malformed-range flags from the last accepted job |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |

## Verification
The hardest situation to reach is the hand-off between channels. When channel 0's last address and the reload of channel 1's first address fall on the same edge, one gap cycle or one duplicated address would break R3. A start strobe arriving during a run adds a second hazard. The stimulus places regions of one to five words back to back, including a region that ends one below the top of the address space. It also pulses start during the first write with different parameters and scrambles every parameter input right after acceptance. The expected write stream is then compared cycle by cycle against one rebuilt from the original parameters.

// File: rtl/mfill_pkg.sv
// Package: shared types for the memory fill engine.
// Assumes exactly two channels; the sequencer state encodes the channel order.
package mfill_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN0 = 2'd1,
        ST_RUN1 = 2'd2,
        ST_FIN  = 2'd3
    } fill_state_t;
endpackage

// File: rtl/mfill_chan_check.sv
// Module: mfill_chan_check
// Classifies one channel's parameters as runnable, disabled or malformed.
// Assumes addresses are unsigned; a zero first address means disabled.
module mfill_chan_check #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] stop_i,
    output logic          run_o,
    output logic          bad_o
);
    logic enabled;

    // Purpose: decide run/bad from enable and range ordering.
    always_comb begin
        enabled = (first_i != '0);
        run_o   = enabled && (stop_i > first_i);
        bad_o   = enabled && (stop_i <= first_i);
    end
endmodule

// File: rtl/mfill_addr_gen.sv
// Module: mfill_addr_gen
// Holds the current write address, loads a channel's first address and steps by one.
// Assumes the limit is strictly above the loaded address, so last_o is reached.
module mfill_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_inc;

    // Purpose: next-address and end-of-region detection.
    always_comb begin
        addr_inc = addr_q + AW'(1);
        last_o   = (addr_inc == limit_i);
        addr_o   = addr_q;
    end

    // Purpose: address register, load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (step_i) begin
            addr_q <= addr_inc;
        end
    end

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_o == $past(addr_o) + AW'(1)))
        else $error("address did not advance by one");
endmodule

// File: rtl/mfill_seq.sv
// Module: mfill_seq
// Job sequencer: accepts a start when idle, runs channel 0 then channel 1,
// then emits a one-cycle done. Assumes run flags are valid at acceptance.
module mfill_seq
    import mfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NUM_CH-1:0] run_i,
    input  logic              last_i,
    output logic              accept_o,
    output logic              load_o,
    output logic              load_from_q_o,
    output logic              cur_ch_o,
    output logic              step_o,
    output logic              busy_o,
    output logic              done_o
);
    fill_state_t state_q, state_d;
    logic        run1_q;

    // Purpose: acceptance, load control and status decode.
    always_comb begin
        accept_o      = start_i && (state_q == ST_IDLE);
        load_from_q_o = (state_q == ST_RUN0) && last_i && run1_q;
        load_o        = (accept_o && (run_i != '0)) || load_from_q_o;
        step_o        = (state_q == ST_RUN0) || (state_q == ST_RUN1);
        cur_ch_o      = (state_q == ST_RUN1);
        busy_o        = (state_q != ST_IDLE);
        done_o        = (state_q == ST_FIN);
    end

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_o) begin
                if (run_i[0])      state_d = ST_RUN0;
                else if (run_i[1]) state_d = ST_RUN1;
                else               state_d = ST_FIN;
            end
            ST_RUN0: if (last_i) state_d = run1_q ? ST_RUN1 : ST_FIN;
            ST_RUN1: if (last_i) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and channel-1 enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run1_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) run1_q <= run_i[1];
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o)
        else $error("busy dropped before done");

    a_r7_no_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !step_o)
        else $error("write during done");
endmodule

// File: rtl/mfill_engine.sv
// Module: mfill_engine (top)
// Two-channel pattern fill over a single-port write interface, one word per cycle.
// Assumes the memory accepts a write every cycle with no back-pressure.
module mfill_engine
    import mfill_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] c0_first_i,
    input  logic [AW-1:0] c0_stop_i,
    input  logic [DW-1:0] c0_pattern_i,
    input  logic [AW-1:0] c1_first_i,
    input  logic [AW-1:0] c1_stop_i,
    input  logic [DW-1:0] c1_pattern_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    err_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);
    logic [AW-1:0]     first_in [NUM_CH];
    logic [AW-1:0]     stop_in  [NUM_CH];
    logic [DW-1:0]     pat_in   [NUM_CH];
    logic [AW-1:0]     first_q  [NUM_CH];
    logic [AW-1:0]     stop_q   [NUM_CH];
    logic [DW-1:0]     pat_q    [NUM_CH];
    logic [NUM_CH-1:0] run, bad, err_q;
    logic              accept, load, load_from_q, cur_ch, step, last;
    logic [AW-1:0]     load_val, addr;

    // Purpose: gather per-channel inputs into arrays.
    always_comb begin
        first_in[0] = c0_first_i;   first_in[1] = c1_first_i;
        stop_in[0]  = c0_stop_i;    stop_in[1]  = c1_stop_i;
        pat_in[0]   = c0_pattern_i; pat_in[1]   = c1_pattern_i;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        mfill_chan_check #(.AW(AW)) u_chk (
            .first_i (first_in[g]),
            .stop_i  (stop_in[g]),
            .run_o   (run[g]),
            .bad_o   (bad[g])
        );
    end

    // Purpose: capture channel parameters and error flags on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                first_q[i] <= '0;
                stop_q[i]  <= '0;
                pat_q[i]   <= '0;
            end
            err_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < NUM_CH; i++) begin
                first_q[i] <= first_in[i];
                stop_q[i]  <= stop_in[i];
                pat_q[i]   <= pat_in[i];
            end
            err_q <= bad;
        end
    end

    mfill_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .run_i         (run),
        .last_i        (last),
        .accept_o      (accept),
        .load_o        (load),
        .load_from_q_o (load_from_q),
        .cur_ch_o      (cur_ch),
        .step_o        (step),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    // Purpose: pick the address loaded at acceptance or at the channel hand-off.
    always_comb begin
        if (load_from_q) load_val = first_q[1];
        else if (run[0]) load_val = first_in[0];
        else             load_val = first_in[1];
    end

    mfill_addr_gen #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .step_i     (step),
        .limit_i    (stop_q[cur_ch]),
        .addr_o     (addr),
        .last_o     (last)
    );

    // Purpose: drive the memory write port and status.
    always_comb begin
        mem_we_o    = step;
        mem_addr_o  = addr;
        mem_wdata_o = pat_q[cur_ch];
        err_o       = err_q;
    end

    a_r4_no_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o != '0))
        else $error("write to address zero");

    a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(err_o))
        else $error("error flags changed without a new job");

    a_r5_bad_ch0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad[0]) |=> !(mem_we_o && !cur_ch))
        else $error("malformed channel 0 wrote");

    a_r2_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o < stop_q[cur_ch]))
        else $error("write beyond stop address");
endmodule

// File: tb/mfill_engine_bench.sv
`timescale 1ns/1ps
module mfill_engine_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] c0_first_i = '0, c0_stop_i = '0, c1_first_i = '0, c1_stop_i = '0;
    logic [DW-1:0] c0_pattern_i = '0, c1_pattern_i = '0;
    logic          busy_o, done_o, mem_we_o;
    logic [1:0]    err_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    mfill_engine #(.AW(AW), .DW(DW)) u_mfill_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .c0_first_i(c0_first_i), .c0_stop_i(c0_stop_i), .c0_pattern_i(c0_pattern_i),
        .c1_first_i(c1_first_i), .c1_stop_i(c1_stop_i), .c1_pattern_i(c1_pattern_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk("R1", "busy", 64'(busy_o), 0);
        chk("R1", "done", 64'(done_o), 0);
        chk("R1", "we",   64'(mem_we_o), 0);
        chk("R1", "err",  64'(err_o), 0);
    endtask

    // Generic job: checks every cycle from acceptance to idle.
    task automatic run_case(input string tag,
                            input logic [AW-1:0] b0, input logic [AW-1:0] s0, input logic [DW-1:0] p0,
                            input logic [AW-1:0] b1, input logic [AW-1:0] s1, input logic [DW-1:0] p1,
                            input bit poke);
        logic [AW-1:0] b [2];
        logic [AW-1:0] s [2];
        logic [DW-1:0] p [2];
        logic [1:0]    exp_err;
        int            n;
        b[0] = b0; s[0] = s0; p[0] = p0;
        b[1] = b1; s[1] = s1; p[1] = p1;
        for (int c = 0; c < 2; c++) exp_err[c] = (b[c] != 0) && (s[c] <= b[c]);
        @(negedge clk);
        c0_first_i = b0; c0_stop_i = s0; c0_pattern_i = p0;
        c1_first_i = b1; c1_stop_i = s1; c1_pattern_i = p1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R9: scramble inputs after capture
        c0_first_i = 16'h0003; c0_stop_i = 16'h0009; c0_pattern_i = 32'hBAD0BAD0;
        c1_first_i = 16'h0005; c1_stop_i = 16'h0002; c1_pattern_i = 32'hBAD1BAD1;
        chk("R8", {tag, " busy after accept"}, 64'(busy_o), 1);
        chk("R6", {tag, " err after accept"}, 64'(err_o), 64'(exp_err));
        n = 0;
        for (int c = 0; c < 2; c++) begin
            if (b[c] != 0 && s[c] > b[c]) begin
                for (int a = int'(b[c]); a < int'(s[c]); a++) begin
                    if (n > 0) @(negedge clk);
                    chk(c == 0 ? "R2" : "R3", {tag, " we"},   64'(mem_we_o), 1);
                    chk(c == 0 ? "R2" : "R3", {tag, " addr"}, 64'(mem_addr_o), 64'(a));
                    chk("R9", {tag, " data"}, 64'(mem_wdata_o), 64'(p[c]));
                    chk("R7", {tag, " no early done"}, 64'(done_o), 0);
                    if (poke && n == 0) begin
                        // R8: start while busy with other parameters
                        start_i = 1'b1;
                        c0_first_i = 16'h0700; c0_stop_i = 16'h0600;
                        c1_first_i = 16'h0001; c1_stop_i = 16'h0002;
                    end
                    if (n == 1) start_i = 1'b0;
                    n++;
                end
            end
        end
        if (n > 0) @(negedge clk);
        start_i = 1'b0;
        chk("R7", {tag, " done"}, 64'(done_o), 1);
        chk("R7", {tag, " no write at done"}, 64'(mem_we_o), 0);
        chk("R8", {tag, " busy at done"}, 64'(busy_o), 1);
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, 64'(done_o), 0);
        chk("R8", {tag, " idle"}, 64'(busy_o), 0);
        chk("R8", {tag, " no restart"}, 64'(mem_we_o), 0);
        chk("R6", {tag, " err held"}, 64'(err_o), 64'(exp_err));
        @(negedge clk);
        chk("R8", {tag, " stays idle"}, 64'(busy_o), 0);
    endtask

    task automatic t_both();    run_case("both",   16'h0010, 16'h0014, 32'hA5A5_0001, 16'h0040, 16'h0043, 32'h5A5A_0002, 1'b0); endtask
    task automatic t_skip0();   run_case("R4 skip0", 16'h0000, 16'h0020, 32'h1111_1111, 16'h0200, 16'h0202, 32'h2222_2222, 1'b0); endtask
    task automatic t_bad1();    run_case("R5 bad1", 16'h0100, 16'h0102, 32'h3333_3333, 16'h0050, 16'h0050, 32'h4444_4444, 1'b0); endtask
    task automatic t_bad0();    run_case("R5 bad0", 16'h0090, 16'h0080, 32'h5555_5555, 16'h0030, 16'h0031, 32'h6666_6666, 1'b0); endtask
    task automatic t_none();    run_case("R4 none", 16'h0000, 16'h0005, 32'h7777_7777, 16'h0000, 16'h0000, 32'h8888_8888, 1'b0); endtask
    task automatic t_busy();    run_case("R8 poke", 16'h0020, 16'h0025, 32'h9999_0000, 16'h0060, 16'h0062, 32'h0000_9999, 1'b1); endtask
    task automatic t_edge();    run_case("R2 top",  16'hFFFE, 16'hFFFF, 32'hCAFE_F00D, 16'h0001, 16'h0002, 32'hDEAD_BEEF, 1'b0); endtask
    task automatic t_bothbad(); run_case("R5 both", 16'h0008, 16'h0004, 32'h0, 16'h0009, 16'h0009, 32'h0, 1'b0); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_both();
        t_skip0();
        t_bad1();
        t_bad0();
        t_none();
        t_busy();
        t_edge();
        t_bothbad();
        t_both();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule